// File: doc/BRIEF.md
# Interrupt Distributor Global Control and Type Registers

This block holds the global control word of an interrupt distributor and serves the read-only type word beside it. It sits on a 32-bit register bus where every access carries a secure/non-secure attribute. The control word holds three group enables, a sticky single-security-state flag, and two affinity-routing flags. A secure agent and a non-secure agent each see a different slice of that word and may change a different set of its bits. The enables and the single-security flag leave the block as registered outputs, so the rest of the distributor can use them.

The type word is put together from elaboration parameters: the number of implemented interrupt lines and the architecture revision. Two configuration inputs say whether locality-specific interrupts and non-maskable interrupts are supported. One bit of the type word follows the live single-security flag. Each read is answered exactly one clock after its request. Each write takes effect on the clock edge that accepts it.

Top module: `dctl_regs`

## Requirements
- R1: After reset with `SINGLE_SEC=0`, all enable outputs and `ds_mode` are 0. A secure read of the control word (byte offset 0x00) returns 0x0000_0030.
- R2: With the single-security flag (control bit 6) clear, a secure write changes only control bits 0, 1, 2 and 6. Every other bit it carries is ignored.
- R3: With control bit 6 clear, a non-secure write changes only bit 1 (the non-secure group-1 enable). Bits 0, 2 and 6 keep their values.
- R4: A write that sets bit 6 also clears bit 2 (the secure group-1 enable) and bit 5 (the non-secure affinity-routing flag). Bit 6 is never cleared by a write; only reset clears it.
- R5: With bit 6 set, a write of either security attribute changes only bits 0 and 1.
- R6: Control bit 4 always reads as one. Bit 5 reads as one until bit 6 is set. Bit 31 (write pending) always reads as zero.
- R7: A non-secure read with bit 6 clear returns only bits 31, 4 and 1 of the secure view. With bit 6 set, a non-secure read returns the full secure view.
- R8: The type word (byte offset 0x04) reads with these fields:
  - bits 25 and 24 set;
  - bits [23:19] = 0xF;
  - bit 18 set only when `REVISION >= 4`;
  - bit 17 = `cfg_lpi_en`;
  - bit 9 = `cfg_nmi_en`;
  - bits [4:0] = `NUM_IRQ/32 - 1`;
  - all other bits except bit 10 are zero.
- R9: Type bit 10 equals the inverse of control bit 6, following it from the next read on.
- R10: Writes to the type word, and writes to any other offset, change no state. Reads of any offset other than 0x00 and 0x04 return zero.
- R11: A read request gives `rsp_valid` high with its data exactly one cycle later. `rsp_valid` is low in every other cycle. `en_grp0`, `en_grp1ns`, `en_grp1s` and `ds_mode` equal control bits 0, 1, 2 and 6.
- R12: With `SINGLE_SEC=1`, reset leaves bit 6 set, bit 5 clear and all enables clear, so a secure control read returns 0x0000_0050.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_secure | input | 1 | 1 = secure access |
| req_addr | input | ADDR_W | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 32 | Read data |
| cfg_lpi_en | input | 1 | Locality-specific interrupt support, shown in type bit 17 |
| cfg_nmi_en | input | 1 | Non-maskable interrupt support, shown in type bit 9 |
| en_grp0 | output | 1 | Group 0 enable |
| en_grp1ns | output | 1 | Non-secure group 1 enable |
| en_grp1s | output | 1 | Secure group 1 enable |
| ds_mode | output | 1 | Single-security-state flag |

## Verification
The bench checks that a non-secure write of all ones cannot reach bits 0 and 2 or set the single-security flag. A design with a shared write mask would instead turn on secure enables from the non-secure side. It sets the flag with all enables high and checks that the secure group-1 enable and the affinity bit drop at once, then tries to write the flag back to zero. A design that got this wrong would leave a secure enable alive, or would let software leave single-security mode. It reads the non-secure view before and after the flag is set, and checks that the type word's security bit follows the flag. A second instance checks the single-security reset value, the revision-dependent bit and a small line count.

// File: rtl/dctl_pkg.sv
package dctl_pkg;
  localparam int WORD_W = 32;

  // Control word bit positions (decoded by the rest of the distributor)
  localparam int B_EN0   = 0;
  localparam int B_EN1NS = 1;
  localparam int B_EN1S  = 2;
  localparam int B_ARES  = 4;
  localparam int B_ARENS = 5;
  localparam int B_DS    = 6;
  localparam int B_RWP   = 31;

  // Type word bit positions
  localparam int T_A3V    = 24;
  localparam int T_NO1N   = 25;
  localparam int T_IDLSB  = 19;
  localparam int T_DVIS   = 18;
  localparam int T_LPIS   = 17;
  localparam int T_SECEXT = 10;
  localparam int T_NMI    = 9;

  // Register byte offsets
  localparam int OFS_CTRL = 0;
  localparam int OFS_TYPE = 4;

  typedef struct packed {
    logic ds;
    logic are_ns;
    logic en1s;
    logic en1ns;
    logic en0;
  } ctrl_state_t;
endpackage

// File: rtl/dctl_ctrl_reg.sv
module dctl_ctrl_reg
  import dctl_pkg::*;
#(
  parameter bit SINGLE_SEC = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_secure,
  input  logic [WORD_W-1:0] wr_data,
  output ctrl_state_t       state
);
  localparam logic [WORD_W-1:0] M_DS_SET = (WORD_W'(1) << B_EN0) | (WORD_W'(1) << B_EN1NS);
  localparam logic [WORD_W-1:0] M_SEC    = M_DS_SET | (WORD_W'(1) << B_EN1S) | (WORD_W'(1) << B_DS);
  localparam logic [WORD_W-1:0] M_NSEC   = WORD_W'(1) << B_EN1NS;

  logic [WORD_W-1:0] wmask;
  logic [WORD_W-1:0] cur_w;
  logic [WORD_W-1:0] nxt_w;
  ctrl_state_t       nxt;
  logic              unused_nxt;

  always_comb begin
    if (state.ds)      wmask = M_DS_SET;
    else if (wr_secure) wmask = M_SEC;
    else               wmask = M_NSEC;
  end

  always_comb begin
    cur_w          = '0;
    cur_w[B_EN0]   = state.en0;
    cur_w[B_EN1NS] = state.en1ns;
    cur_w[B_EN1S]  = state.en1s;
    cur_w[B_ARENS] = state.are_ns;
    cur_w[B_DS]    = state.ds;
    nxt_w          = (cur_w & ~wmask) | (wr_data & wmask);
  end

  assign unused_nxt = ^{nxt_w[WORD_W-1:B_DS+1], nxt_w[B_ARENS:B_ARES]};

  always_comb begin
    nxt.en0    = nxt_w[B_EN0];
    nxt.en1ns  = nxt_w[B_EN1NS];
    nxt.en1s   = nxt_w[B_EN1S];
    nxt.ds     = nxt_w[B_DS];
    nxt.are_ns = state.are_ns;
    if (nxt_w[B_DS] && !state.ds) begin
      nxt.en1s   = 1'b0;
      nxt.are_ns = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state.en0    <= 1'b0;
      state.en1ns  <= 1'b0;
      state.en1s   <= 1'b0;
      state.ds     <= SINGLE_SEC;
      state.are_ns <= ~SINGLE_SEC;
    end else if (wr_en) begin
      state <= nxt;
    end
  end
endmodule

// File: rtl/dctl_view.sv
module dctl_view
  import dctl_pkg::*;
#(
  parameter int NUM_IRQ  = 256,
  parameter int REVISION = 3
) (
  input  ctrl_state_t       state,
  input  logic              rd_secure,
  input  logic              sel_ctrl,
  input  logic              sel_type,
  input  logic              cfg_lpi_en,
  input  logic              cfg_nmi_en,
  output logic [WORD_W-1:0] rd_data
);
  localparam int          LINES_M1 = (NUM_IRQ / 32) - 1;
  localparam logic        HAS_DVIS = (REVISION >= 4);
  localparam logic [WORD_W-1:0] TYPE_FIXED =
      (WORD_W'(1) << T_NO1N) | (WORD_W'(1) << T_A3V) |
      (WORD_W'(4'hF) << T_IDLSB) | (WORD_W'(HAS_DVIS) << T_DVIS) |
      WORD_W'(LINES_M1 & 5'h1F);
  localparam logic [WORD_W-1:0] NS_VIEW =
      (WORD_W'(1) << B_RWP) | (WORD_W'(1) << B_ARES) | (WORD_W'(1) << B_EN1NS);

  logic [WORD_W-1:0] sec_view;
  logic [WORD_W-1:0] ctrl_view;
  logic [WORD_W-1:0] type_view;

  always_comb begin
    sec_view          = '0;
    sec_view[B_EN0]   = state.en0;
    sec_view[B_EN1NS] = state.en1ns;
    sec_view[B_EN1S]  = state.en1s;
    sec_view[B_ARES]  = 1'b1;
    sec_view[B_ARENS] = state.are_ns;
    sec_view[B_DS]    = state.ds;
    sec_view[B_RWP]   = 1'b0;
    ctrl_view = (rd_secure || state.ds) ? sec_view : (sec_view & NS_VIEW);
  end

  always_comb begin
    type_view           = TYPE_FIXED;
    type_view[T_LPIS]   = cfg_lpi_en;
    type_view[T_NMI]    = cfg_nmi_en;
    type_view[T_SECEXT] = ~state.ds;
  end

  always_comb begin
    if (sel_ctrl)      rd_data = ctrl_view;
    else if (sel_type) rd_data = type_view;
    else               rd_data = '0;
  end
endmodule

// File: rtl/dctl_regs.sv
module dctl_regs
  import dctl_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int NUM_IRQ    = 256,
  parameter int REVISION   = 3,
  parameter bit SINGLE_SEC = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_secure,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  input  logic              cfg_lpi_en,
  input  logic              cfg_nmi_en,
  output logic              en_grp0,
  output logic              en_grp1ns,
  output logic              en_grp1s,
  output logic              ds_mode
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_TYPE = ADDR_W'(OFS_TYPE);

  logic              sel_ctrl;
  logic              sel_type;
  logic              ctrl_wr;
  logic              rd_req;
  logic [WORD_W-1:0] rd_next;
  ctrl_state_t       state;

  assign sel_ctrl = (req_addr == A_CTRL);
  assign sel_type = (req_addr == A_TYPE);
  assign ctrl_wr  = req_valid && req_write && sel_ctrl;
  assign rd_req   = req_valid && !req_write;

  dctl_ctrl_reg #(.SINGLE_SEC(SINGLE_SEC)) ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (ctrl_wr),
    .wr_secure (req_secure),
    .wr_data   (req_wdata),
    .state     (state)
  );

  dctl_view #(.NUM_IRQ(NUM_IRQ), .REVISION(REVISION)) view_i (
    .state      (state),
    .rd_secure  (req_secure),
    .sel_ctrl   (sel_ctrl),
    .sel_type   (sel_type),
    .cfg_lpi_en (cfg_lpi_en),
    .cfg_nmi_en (cfg_nmi_en),
    .rd_data    (rd_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_req;
      rsp_rdata <= rd_req ? rd_next : '0;
    end
  end

  assign en_grp0   = state.en0;
  assign en_grp1ns = state.en1ns;
  assign en_grp1s  = state.en1s;
  assign ds_mode   = state.ds;
endmodule

// File: rtl/dctl_regs_chk.sv
module dctl_regs_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_write,
  input logic              req_secure,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic              en_grp0,
  input logic              en_grp1s,
  input logic              ds_mode
);
  AST_DS_STICKY: assert property (@(posedge clk) disable iff (rst)
    ds_mode |=> ds_mode); // R4

  AST_DS_DROPS_S1: assert property (@(posedge clk) disable iff (rst)
    $rose(ds_mode) |-> !en_grp1s); // R4

  AST_NS_WRITE_LIMIT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && !req_secure && !ds_mode && req_addr == '0)
      |=> ($stable(en_grp0) && $stable(en_grp1s) && $stable(ds_mode))); // R3

  AST_OTHER_ADDR_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && req_addr != '0)
      |=> ($stable(en_grp0) && $stable(en_grp1s) && $stable(ds_mode))); // R10

  AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write) |=> rsp_valid); // R11

  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && !req_write) |=> !rsp_valid); // R11
endmodule

bind dctl_regs dctl_regs_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_write  (req_write),
  .req_secure (req_secure),
  .req_addr   (req_addr),
  .rsp_valid  (rsp_valid),
  .en_grp0    (en_grp0),
  .en_grp1s   (en_grp1s),
  .ds_mode    (ds_mode)
);

// File: tb/dctl_regs_tb_top.sv
module dctl_regs_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 22;

  typedef struct packed {
    logic        wr;
    logic        sec;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [7:0]  req;
  } vec_t;

  // Walk from reset on instance A (NUM_IRQ=256, REVISION=3, lpi=1, nmi=0)
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b1, 8'h00, 32'h0000_0030, 8'd1},  // R1 secure reset view
    '{1'b0, 1'b0, 8'h00, 32'h0000_0010, 8'd7},  // R7 ns view, ds clear
    '{1'b0, 1'b1, 8'h04, 32'h037A_0407, 8'd8},  // R8 type word
    '{1'b1, 1'b1, 8'h00, 32'hFFFF_FFBF, 8'd2},  // R2 secure write all but bit 6
    '{1'b0, 1'b1, 8'h00, 32'h0000_0037, 8'd2},  // R2, R6 bit31 stays zero
    '{1'b0, 1'b0, 8'h00, 32'h0000_0012, 8'd7},  // R7 only 31,4,1
    '{1'b1, 1'b0, 8'h00, 32'h0000_0000, 8'd3},  // R3 ns write zero
    '{1'b0, 1'b1, 8'h00, 32'h0000_0035, 8'd3},  // R3 only bit 1 cleared
    '{1'b1, 1'b0, 8'h00, 32'hFFFF_FFFF, 8'd3},  // R3 ns write ones
    '{1'b0, 1'b1, 8'h00, 32'h0000_0037, 8'd3},  // R3 ds not set by ns
    '{1'b1, 1'b1, 8'h00, 32'h0000_0000, 8'd2},  // R2 secure clears enables
    '{1'b0, 1'b1, 8'h00, 32'h0000_0030, 8'd2},  // R2
    '{1'b1, 1'b1, 8'h04, 32'h0000_0000, 8'd10}, // R10 write to type
    '{1'b0, 1'b1, 8'h04, 32'h037A_0407, 8'd10}, // R10 type unchanged
    '{1'b0, 1'b1, 8'h08, 32'h0000_0000, 8'd10}, // R10 other offset reads 0
    '{1'b1, 1'b1, 8'h00, 32'h0000_0047, 8'd4},  // R4 set ds with all enables
    '{1'b0, 1'b1, 8'h00, 32'h0000_0053, 8'd4},  // R4 bits 2 and 5 dropped
    '{1'b0, 1'b0, 8'h00, 32'h0000_0053, 8'd7},  // R7 ns full view once ds set
    '{1'b0, 1'b1, 8'h04, 32'h037A_0007, 8'd9},  // R9 sec-ext bit follows ds
    '{1'b1, 1'b1, 8'h00, 32'h0000_0004, 8'd4},  // R4, R5 write ds=0, bit2=1
    '{1'b0, 1'b1, 8'h00, 32'h0000_0050, 8'd5},  // R5 ds kept, bit2 ignored
    '{1'b1, 1'b0, 8'h00, 32'h0000_0003, 8'd5}   // R5 ns may write bits 0,1
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0, req_secure = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid_a, rsp_valid_b;
  logic [31:0] rsp_rdata_a, rsp_rdata_b;
  logic        e0_a, e1ns_a, e1s_a, ds_a;
  logic        e0_b, e1ns_b, e1s_b, ds_b;
  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dctl_regs #(.ADDR_W(8), .NUM_IRQ(256), .REVISION(3), .SINGLE_SEC(1'b0)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_secure(req_secure), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid_a), .rsp_rdata(rsp_rdata_a),
    .cfg_lpi_en(1'b1), .cfg_nmi_en(1'b0),
    .en_grp0(e0_a), .en_grp1ns(e1ns_a), .en_grp1s(e1s_a), .ds_mode(ds_a)
  );

  dctl_regs #(.ADDR_W(8), .NUM_IRQ(64), .REVISION(4), .SINGLE_SEC(1'b1)) dut_b_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_secure(req_secure), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid_b), .rsp_rdata(rsp_rdata_b),
    .cfg_lpi_en(1'b0), .cfg_nmi_en(1'b1),
    .en_grp0(e0_b), .en_grp1ns(e1ns_b), .en_grp1s(e1s_b), .ds_mode(ds_b)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic sec, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_secure = sec; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  // Issues a read; after return, response of both instances is visible
  task automatic do_read(input logic sec, input logic [7:0] a);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_secure = sec; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 outputs after reset
    check("R1 enables/ds", {28'd0, e0_a, e1ns_a, e1s_a, ds_a}, 32'h0);
    check("R11 no rsp when idle", {31'd0, rsp_valid_a}, 32'h0);
    // R12 second instance reset view and type word
    do_read(1'b1, 8'h00);
    check("R12 single-sec reset ctrl", rsp_rdata_b, 32'h0000_0050);
    check("R11 rsp_valid after read", {31'd0, rsp_valid_a}, 32'h1);
    @(negedge clk);
    check("R11 rsp_valid drops", {31'd0, rsp_valid_a}, 32'h0);
    do_read(1'b0, 8'h04);
    check("R8 type rev4 nmi small", rsp_rdata_b, 32'h037C_0201);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr) begin
        do_write(VEC[i].sec, VEC[i].addr, VEC[i].data);
      end else begin
        do_read(VEC[i].sec, VEC[i].addr);
        check($sformatf("R%0d vec %0d", VEC[i].req, i), rsp_rdata_a, VEC[i].data);
      end
    end
    // R11 outputs track control bits 0,1,2,6 (state 0x53)
    check("R11 outputs", {28'd0, e0_a, e1ns_a, e1s_a, ds_a}, 32'hD);
    // R4 reset clears ds
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R4 reset clears ds", {31'd0, ds_a}, 32'h0);
    do_read(1'b1, 8'h00);
    check("R6 bit5 back after reset", rsp_rdata_a, 32'h0000_0030);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule